// File: doc/BRIEF.md
# Parallel Port Forward Command/Data Sequencer

This block merges two host-side byte streams into the single outbound byte stream that a parallel peripheral link carries in the forward direction. One input stream holds command bytes and the other holds ordinary data bytes. Every byte leaves on a shared byte path together with one tag bit, which plays the role of the host acknowledge line: high marks data and low marks a command. The tag is the only thing that tells the two kinds of byte apart on the way out.

The top bit of a command byte selects its kind. When it is 0, the low seven bits are a run-length count, where 0 means one copy and 127 means 128 copies of the data byte that follows. When it is 1, the low seven bits are a channel address. To send a compressed run, software puts the count in the command stream and the repeated byte in the data stream. Commands win arbitration, so a count always goes out just ahead of the byte it governs. If a count is followed directly by another command instead of a data byte, the block sets a sticky protocol-error flag.

The output is a single registered holding stage with valid/ready flow control. An input is taken whenever the stage is empty or is being drained in the same cycle, so a transfer of one byte is never blocked longer than the downstream stalls.

Top module: `ppfwd_seq`

## Requirements
- R1: A byte taken from the command input leaves with `out_tag` = 0 and a byte taken from the data input leaves with `out_tag` = 1, in both cases with the byte value unchanged.
- R2: When command and data inputs are both valid in a cycle where the stage accepts, the command byte is taken and `dat_ready` stays low.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_tag` keep their values on the next cycle.
- R4: `cmd_ready` is high exactly when the holding stage is empty or `out_ready` is high; `dat_ready` is the same condition with `cmd_valid` low.
- R5: When a command with bit 7 = 0 (run-length count) is emitted and the next emitted byte is also a command, `proto_err` goes high in the cycle that second command appears on the output.
- R6: A command with bit 7 = 1 (channel address) followed by any byte, or a count followed by a data byte, does not set `proto_err`.
- R7: Once set, `proto_err` stays high until reset.
- R8: Synchronous reset `rst` empties the holding stage (`out_valid` = 0) and clears `proto_err`.
- R9: Every accepted byte appears on the output exactly once, in acceptance order, and leaves with one handshake.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_byte | input | 8 | Command byte: bit 7 kind, bits 6:0 count or address |
| cmd_ready | output | 1 | Command byte taken this cycle when valid |
| dat_valid | input | 1 | Data byte offered |
| dat_byte | input | 8 | Data byte |
| dat_ready | output | 1 | Data byte taken this cycle when valid |
| out_valid | output | 1 | Outbound byte present |
| out_byte | output | 8 | Outbound byte |
| out_tag | output | 1 | Host acknowledge tag: 1 data, 0 command |
| out_ready | input | 1 | Downstream takes the outbound byte |
| proto_err | output | 1 | Sticky: a count was followed by another command |

## Verification
The bench builds the block with its default byte width of 8, which is the only width at which the kind bit sits at bit 7 and the count range of 0 to 127 holds. At that width directed sequences reach the count-then-command error, address-then-address and count-then-data cases, the largest count 0x7F, a long stall with both inputs waiting, and random mixes of both streams under random downstream back-pressure, all compared each cycle against a queue-based model.

// File: rtl/ppfwd_pkg.sv
package ppfwd_pkg;
  parameter int unsigned PF_BYTE_W = 8;
  typedef enum logic {
    TAG_CMD  = 1'b0,
    TAG_DATA = 1'b1
  } tag_e;
endpackage

// File: rtl/ppfwd_arb.sv
module ppfwd_arb #(
  parameter int unsigned BYTE_W = ppfwd_pkg::PF_BYTE_W
) (
  input  logic              slot_free,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  input  logic              dat_valid,
  input  logic [BYTE_W-1:0] dat_byte,
  output logic              cmd_ready,
  output logic              dat_ready,
  output logic              load,
  output logic [BYTE_W-1:0] sel_byte,
  output ppfwd_pkg::tag_e   sel_tag
);
  import ppfwd_pkg::*;

  always_comb begin
    cmd_ready = slot_free;
    dat_ready = slot_free && !cmd_valid;
    load      = slot_free && (cmd_valid || dat_valid);
    if (cmd_valid) begin
      sel_byte = cmd_byte;
      sel_tag  = TAG_CMD;
    end else begin
      sel_byte = dat_byte;
      sel_tag  = TAG_DATA;
    end
  end
endmodule

// File: rtl/ppfwd_hold.sv
module ppfwd_hold #(
  parameter int unsigned BYTE_W = ppfwd_pkg::PF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] in_byte,
  input  ppfwd_pkg::tag_e   in_tag,
  input  logic              out_ready,
  output logic              slot_free,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output ppfwd_pkg::tag_e   out_tag
);
  import ppfwd_pkg::*;

  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_byte  <= '0;
      out_tag   <= TAG_DATA;
    end else if (slot_free) begin
      out_valid <= load;
      if (load) begin
        out_byte <= in_byte;
        out_tag  <= in_tag;
      end
    end
  end

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_tag)));
endmodule

// File: rtl/ppfwd_err.sv
module ppfwd_err #(
  parameter int unsigned BYTE_W = ppfwd_pkg::PF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] sel_byte,
  input  ppfwd_pkg::tag_e   sel_tag,
  output logic              proto_err
);
  import ppfwd_pkg::*;
  localparam int unsigned KIND_BIT = BYTE_W - 1;

  logic count_pending;
  logic is_cmd;

  assign is_cmd = (sel_tag == TAG_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      count_pending <= 1'b0;
      proto_err     <= 1'b0;
    end else if (load) begin
      count_pending <= is_cmd && !sel_byte[KIND_BIT];
      if (is_cmd && count_pending) proto_err <= 1'b1;
    end
  end

  // R5
  count_then_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (load && is_cmd && count_pending) |=> proto_err);

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> proto_err);
endmodule

// File: rtl/ppfwd_seq.sv
module ppfwd_seq #(
  parameter int unsigned BYTE_W = ppfwd_pkg::PF_BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [BYTE_W-1:0] cmd_byte,
  output logic              cmd_ready,
  input  logic              dat_valid,
  input  logic [BYTE_W-1:0] dat_byte,
  output logic              dat_ready,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic              out_tag,
  input  logic              out_ready,
  output logic              proto_err
);
  import ppfwd_pkg::*;

  logic              slot_free;
  logic              load;
  logic [BYTE_W-1:0] sel_byte;
  tag_e              sel_tag;
  tag_e              held_tag;

  ppfwd_arb #(.BYTE_W(BYTE_W)) u_arb (
    .slot_free (slot_free),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .dat_valid (dat_valid),
    .dat_byte  (dat_byte),
    .cmd_ready (cmd_ready),
    .dat_ready (dat_ready),
    .load      (load),
    .sel_byte  (sel_byte),
    .sel_tag   (sel_tag)
  );

  ppfwd_hold #(.BYTE_W(BYTE_W)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .in_byte   (sel_byte),
    .in_tag    (sel_tag),
    .out_ready (out_ready),
    .slot_free (slot_free),
    .out_valid (out_valid),
    .out_byte  (out_byte),
    .out_tag   (held_tag)
  );

  ppfwd_err #(.BYTE_W(BYTE_W)) u_err (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sel_byte  (sel_byte),
    .sel_tag   (sel_tag),
    .proto_err (proto_err)
  );

  assign out_tag = held_tag;

  // R2
  cmd_first_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && dat_valid && cmd_ready) |=> (out_valid && out_tag == TAG_CMD));

  // R4
  empty_takes_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (cmd_ready && (cmd_valid || dat_ready)));

  // R1
  cmd_tag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> (out_tag == TAG_CMD && out_byte == $past(cmd_byte)));
endmodule

// File: tb/test_ppfwd_seq.sv
`timescale 1ns/1ps
module test_ppfwd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cmd_valid = 1'b0, dat_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] cmd_byte = '0, dat_byte = '0;
  logic       cmd_ready, dat_ready, out_valid, out_tag, proto_err;
  logic [7:0] out_byte;

  always #2.5 clk = ~clk;

  ppfwd_seq i_ppfwd_seq (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .cmd_ready(cmd_ready),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .dat_ready(dat_ready),
    .out_valid(out_valid), .out_byte(out_byte), .out_tag(out_tag),
    .out_ready(out_ready), .proto_err(proto_err)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] cq[$];
  logic [7:0] dq[$];
  logic       m_ov = 1'b0, m_tag = 1'b0, m_err = 1'b0, m_cnt = 1'b0;
  logic [7:0] m_byte = '0;
  int         cycles = 0;
  bit         finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  // One clock: compare against model, drive, then advance model.
  task automatic step(input logic rdy);
    logic free;
    @(negedge clk);
    chk(out_valid == m_ov, "R9 out_valid", out_valid, m_ov);
    if (m_ov) begin
      chk(out_byte == m_byte, "R9 out_byte", out_byte, m_byte);
      chk(out_tag == m_tag, "R1 out_tag", out_tag, m_tag);
    end
    chk(proto_err == m_err, "R5/R6/R7 proto_err", proto_err, m_err);
    out_ready = rdy;
    cmd_valid = (cq.size() > 0);
    cmd_byte  = cmd_valid ? cq[0] : 8'h00;
    dat_valid = (dq.size() > 0);
    dat_byte  = dat_valid ? dq[0] : 8'h00;
    #0.5;
    free = !m_ov || rdy;
    chk(cmd_ready == free, "R4 cmd_ready", cmd_ready, free);
    chk(dat_ready == (free && !cmd_valid), "R2/R4 dat_ready", dat_ready, free && !cmd_valid);
    if (free) begin
      if (cmd_valid) begin
        m_ov = 1; m_byte = cq[0]; m_tag = 1'b0;
        if (m_cnt) m_err = 1;
        m_cnt = !cq[0][7];
        void'(cq.pop_front());
      end else if (dat_valid) begin
        m_ov = 1; m_byte = dq[0]; m_tag = 1'b1; m_cnt = 0;
        void'(dq.pop_front());
      end else begin
        m_ov = 0;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; cmd_valid = 0; dat_valid = 0; out_ready = 0;
    cq.delete(); dq.delete();
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    m_ov = 0; m_err = 0; m_cnt = 0;
    chk(out_valid == 0, "R8 out_valid after reset", out_valid, 0);
    chk(proto_err == 0, "R8 proto_err after reset", proto_err, 0);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step(1'b1);
  endtask

  initial begin
    do_reset();

    // R2, R6: count then its data byte, both offered together
    cq.push_back(8'h05); dq.push_back(8'hAA);
    step(1'b1);
    step(1'b1);
    chk(out_valid && out_tag == 1'b0 && out_byte == 8'h05, "R2 command first", out_byte, 8'h05);
    drain(3);
    chk(proto_err == 0, "R6 count then data", proto_err, 0);

    // R3: stall with a command held and both inputs waiting
    cq.push_back(8'h7F); cq.push_back(8'h81); dq.push_back(8'h33);
    step(1'b1);
    for (int i = 0; i < 6; i++) step(1'b0);
    chk(out_valid && out_byte == 8'h7F && out_tag == 1'b0, "R3 held under stall", out_byte, 8'h7F);
    drain(5);
    // largest count followed by an address: error expected
    chk(proto_err == 1, "R5 count then address", proto_err, 1);
    dq.push_back(8'h11);
    drain(4);
    chk(proto_err == 1, "R7 sticky", proto_err, 1);

    // R8
    do_reset();

    // R6: address followed by address and by data
    cq.push_back(8'h81); cq.push_back(8'h82); dq.push_back(8'h44);
    drain(6);
    chk(proto_err == 0, "R6 address sequence", proto_err, 0);

    // R5: two counts back to back
    cq.push_back(8'h00); cq.push_back(8'h03);
    drain(4);
    chk(proto_err == 1, "R5 count then count", proto_err, 1);

    do_reset();
    // random mix under back-pressure
    for (int i = 0; i < 3000; i++) begin
      if (cq.size() < 3 && ($urandom % 4) == 0) cq.push_back(8'($urandom));
      if (dq.size() < 3 && ($urandom % 3) == 0) dq.push_back(8'($urandom));
      step(1'(($urandom % 3) != 0));
      if (i == 1500) do_reset();
    end
    drain(10);
    finish_run();
  end
endmodule